// File: doc/BRIEF.md
# UTOPIA Level 2 Multi-PHY Receive Port

This block is the PHY-side receive half of a 16-bit UTOPIA Level 2 bus that carries four PHY ports. Each port keeps its own cell store, which an internal line-side writer fills one 16-bit word at a time. A cell is 27 words long: the 53-byte cell plus one pad byte, in write order. An ATM-layer master shares a 5-bit address bus to poll the ports and to pick the one that sends. Each port answers to its own 5-bit address, which comes from a configuration input.

Polling is registered. The address seen at a clock edge decides the cell-available flag, and the output enable of that flag, for the next cycle. A port is picked when its address is present in a cycle where the active-low enable is high. The transfer starts at the first edge where the enable is low, provided that port holds a complete cell. It then moves one word per enabled edge until all 27 words have gone out. Each word comes with a start-of-cell flag (first word only) and an odd parity bit. The bus pads are outside the block, so an enable output stands in for the undriven state of the cell-available line.

Top module: `u2rx_multiphy`

## Requirements
- R1: One cycle after an edge at which `rx_addr` equals the configured address of any port, `rx_clav_oe` is 1.
- R2: One cycle after an edge at which `rx_addr` matches a port, `rx_clav` is 1 exactly when that port holds at least one complete cell, that is, all 27 of its words have been written.
- R3: One cycle after an edge at which `rx_addr` matches no port, both `rx_clav_oe` and `rx_clav` are 0.
- R4: When two ports share an address, the port with the lower index answers polls and is the one selected.
- R5: A port is selected by its address at an edge where `rx_enb_n` is 1. At the next edge where `rx_enb_n` is 0 and that port holds a cell, the first word of the cell appears on `rx_data` with `rx_soc` = 1.
- R6: Words advance only at edges where `rx_enb_n` is 0. Otherwise `rx_data` holds its value. `rx_soc` is 1 only for the cycle that follows the loading of a cell's first word.
- R7: `rx_prty` is set so that `rx_data` and `rx_prty` together hold an odd number of ones.
- R8: A cell's words come out in the order they were written. Once the 27th word has gone out, that cell is freed. Changes on `rx_addr` while `rx_enb_n` is 0 do not change which port is sending.
- R9: If the selected port holds no complete cell, edges with `rx_enb_n` = 0 start nothing: `rx_soc` stays 0 and `rx_data` holds.
- R10: Each port stores two cells. A cell may be written while another cell of the same port is being read. If a cell's first word arrives while two complete cells are stored, all 27 words of that cell are dropped.
- R11: After a cell ends, a new transfer starts only after the port has been selected again, in a cycle with `rx_enb_n` = 1.
- R12: After reset, `rx_clav`, `rx_clav_oe`, `rx_soc` and `rx_data` are 0, `rx_prty` is 1, and every store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr_cfg | input | 20 | Configured 5-bit address of each port; port i uses bits [5i+4:5i] |
| line_wr_en | input | 1 | Line-side word write strobe |
| line_wr_port | input | 2 | Port that the written word belongs to |
| line_wr_data | input | 16 | Written cell word |
| rx_addr | input | 5 | Poll and select address from the ATM layer |
| rx_enb_n | input | 1 | Active-low enable: the ATM layer accepts a word |
| rx_clav | output | 1 | Cell available for the polled port |
| rx_clav_oe | output | 1 | Drive enable for `rx_clav` |
| rx_data | output | 16 | Cell word toward the ATM layer |
| rx_soc | output | 1 | Start of cell, marks the first word |
| rx_prty | output | 1 | Odd parity over `rx_data` |

## Verification
The hardest case to reach from the ports is the full store. A port must already hold two unread cells when the first word of a third arrives, and only reading can later show that the third cell was dropped. The bench writes three back-to-back cells to one port before any poll, then reads two of them out with enable gaps in the middle. The polls that follow must report the port empty. A second hard case is a cell being written into a port while that same port streams an earlier cell. The bench forks the writer and the reader onto one port, and meanwhile drives a different valid address during enabled cycles so that a wrong reselection would show up in the data.

// File: rtl/u2rx_pkg.sv
package u2rx_pkg;
   localparam int DEF_PORTS      = 4;
   localparam int DEF_WORD_W     = 16;
   localparam int DEF_ADDR_W     = 5;
   localparam int DEF_CELL_WORDS = 27;
   localparam int DEF_CELL_SLOTS = 2;
endpackage

// File: rtl/u2rx_addr_match.sv
module u2rx_addr_match #(
   parameter int NPORT = 4,
   parameter int AW    = 5,
   localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic [NPORT*AW-1:0] cfg_addr,
   input  logic [AW-1:0]       addr,
   output logic                hit,
   output logic [PW-1:0]       hit_port
);
   logic [NPORT-1:0] eq;

   for (genvar g = 0; g < NPORT; g++) begin : g_cmp
      assign eq[g] = (cfg_addr[g*AW +: AW] == addr);
   end

   // lowest index wins when addresses collide
   always_comb begin
      hit_port = '0;
      for (int i = NPORT - 1; i >= 0; i--) begin
         if (eq[i]) hit_port = PW'(i);
      end
   end

   assign hit = |eq;
endmodule

// File: rtl/u2rx_cell_store.sv
module u2rx_cell_store #(
   parameter int DW    = 16,
   parameter int CW    = 27,
   parameter int CELLS = 2,
   localparam int IDX_W = $clog2(CW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DW-1:0]    wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             rd_pop,
   output logic [DW-1:0]    rd_data,
   output logic             cell_avail
);
   localparam int SLOT_W = $clog2(CELLS);
   localparam int MA_W   = $clog2(CELLS * CW);
   localparam int CNT_W  = $clog2(CELLS + 1);

   logic [DW-1:0]     mem [CELLS*CW];
   logic [SLOT_W-1:0] wslot, rslot;
   logic [IDX_W-1:0]  widx;
   logic              wacc_q, acc_now, commit;
   logic [CNT_W-1:0]  count;
   logic [MA_W-1:0]   wr_addr, rd_addr;

   assign acc_now = (widx == '0) ? (count < CNT_W'(CELLS)) : wacc_q;
   assign commit  = wr_en && acc_now && (widx == IDX_W'(CW - 1));
   assign wr_addr = MA_W'(wslot) * MA_W'(CW) + MA_W'(widx);
   assign rd_addr = MA_W'(rslot) * MA_W'(CW) + MA_W'(rd_idx);
   assign rd_data = mem[rd_addr];
   assign cell_avail = (count != '0);

   always_ff @(posedge clk) begin
      if (wr_en && acc_now) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wslot  <= '0;
         rslot  <= '0;
         widx   <= '0;
         wacc_q <= 1'b0;
         count  <= '0;
      end else begin
         if (wr_en) begin
            wacc_q <= acc_now;
            widx   <= (widx == IDX_W'(CW - 1)) ? '0 : widx + 1'b1;
         end
         if (commit)
            wslot <= (wslot == SLOT_W'(CELLS - 1)) ? '0 : wslot + 1'b1;
         if (rd_pop)
            rslot <= (rslot == SLOT_W'(CELLS - 1)) ? '0 : rslot + 1'b1;
         count <= count + CNT_W'(commit) - CNT_W'(rd_pop);
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(CELLS)); // R10
   AST_POP_HAS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop |-> cell_avail); // R8
endmodule

// File: rtl/u2rx_xfer_ctrl.sv
module u2rx_xfer_ctrl #(
   parameter int NPORT = 4,
   parameter int CW    = 27,
   localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int IDX_W = $clog2(CW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enb_n,
   input  logic             hit,
   input  logic [PW-1:0]    hit_port,
   input  logic [NPORT-1:0] cell_avail,
   output logic             load,
   output logic             pop,
   output logic [PW-1:0]    load_port,
   output logic [IDX_W-1:0] load_idx
);
   logic             busy, cand_v, start;
   logic [PW-1:0]    cur, cand;
   logic [IDX_W-1:0] idx;

   assign start     = !busy && !enb_n && cand_v && cell_avail[cand];
   assign load      = !enb_n && (busy || start);
   assign load_port = busy ? cur : cand;
   assign load_idx  = busy ? idx : '0;
   assign pop       = load && (load_idx == IDX_W'(CW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cand_v <= 1'b0;
         cur    <= '0;
         cand   <= '0;
         idx    <= '0;
      end else begin
         if (enb_n) begin
            cand_v <= hit;
            if (hit) cand <= hit_port;
         end
         if (start) begin
            busy   <= 1'b1;
            cur    <= cand;
            cand_v <= 1'b0;
         end
         if (load) idx <= pop ? '0 : load_idx + 1'b1;
         if (pop) busy <= 1'b0;
      end
   end

   AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pop) |=> $stable(cur)); // R8
   AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(idx)); // R6
   AST_START_HAS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !busy) |-> cell_avail[cand]); // R9
endmodule

// File: rtl/u2rx_multiphy.sv
module u2rx_multiphy #(
   parameter int NPORT = u2rx_pkg::DEF_PORTS,
   parameter int DW    = u2rx_pkg::DEF_WORD_W,
   parameter int AW    = u2rx_pkg::DEF_ADDR_W,
   parameter int CW    = u2rx_pkg::DEF_CELL_WORDS,
   parameter int CELLS = u2rx_pkg::DEF_CELL_SLOTS,
   localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT*AW-1:0] port_addr_cfg,
   input  logic                line_wr_en,
   input  logic [PW-1:0]       line_wr_port,
   input  logic [DW-1:0]       line_wr_data,
   input  logic [AW-1:0]       rx_addr,
   input  logic                rx_enb_n,
   output logic                rx_clav,
   output logic                rx_clav_oe,
   output logic [DW-1:0]       rx_data,
   output logic                rx_soc,
   output logic                rx_prty
);
   localparam int IDX_W = $clog2(CW);

   if (CW < 2) begin : g_bad_cw
      $error("cell must span at least two words");
   end
   if (CELLS < 2) begin : g_bad_cells
      $error("each port needs at least two cell slots");
   end
   if (NPORT > (1 << AW)) begin : g_bad_ports
      $error("more ports than addresses");
   end

   logic             hit, load, pop;
   logic [PW-1:0]    hit_port, load_port;
   logic [IDX_W-1:0] load_idx;
   logic [NPORT-1:0] avail;
   logic [DW-1:0]    port_rd [NPORT];
   logic [DW-1:0]    word;

   u2rx_addr_match #(.NPORT(NPORT), .AW(AW)) i_match (
      .cfg_addr (port_addr_cfg),
      .addr     (rx_addr),
      .hit      (hit),
      .hit_port (hit_port)
   );

   u2rx_xfer_ctrl #(.NPORT(NPORT), .CW(CW)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .enb_n      (rx_enb_n),
      .hit        (hit),
      .hit_port   (hit_port),
      .cell_avail (avail),
      .load       (load),
      .pop        (pop),
      .load_port  (load_port),
      .load_idx   (load_idx)
   );

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      u2rx_cell_store #(.DW(DW), .CW(CW), .CELLS(CELLS)) i_store (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (line_wr_en && (line_wr_port == PW'(g))),
         .wr_data    (line_wr_data),
         .rd_idx     (load_idx),
         .rd_pop     (pop && (load_port == PW'(g))),
         .rd_data    (port_rd[g]),
         .cell_avail (avail[g])
      );
   end

   assign word = port_rd[load_port];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_clav    <= 1'b0;
         rx_clav_oe <= 1'b0;
         rx_data    <= '0;
         rx_soc     <= 1'b0;
         rx_prty    <= 1'b1;
      end else begin
         rx_clav_oe <= hit;
         rx_clav    <= hit && avail[hit_port];
         rx_soc     <= load && (load_idx == '0);
         if (load) begin
            rx_data <= word;
            rx_prty <= ~^word;
         end
      end
   end

   AST_CLAV_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clav |-> rx_clav_oe); // R3
endmodule

// File: tb/test_u2rx_multiphy.sv
module test_u2rx_multiphy;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg [4];
   logic        line_wr_en = 1'b0;
   logic [1:0]  line_wr_port = '0;
   logic [15:0] line_wr_data = '0;
   logic [4:0]  rx_addr = 5'h1F;
   logic        rx_enb_n = 1'b1;
   logic        rx_clav, rx_clav_oe, rx_soc, rx_prty;
   logic [15:0] rx_data;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   u2rx_multiphy i_u2rx_multiphy (
      .clk(clk), .rst_n(rst_n),
      .port_addr_cfg({cfg[3], cfg[2], cfg[1], cfg[0]}),
      .line_wr_en(line_wr_en), .line_wr_port(line_wr_port), .line_wr_data(line_wr_data),
      .rx_addr(rx_addr), .rx_enb_n(rx_enb_n),
      .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe), .rx_data(rx_data),
      .rx_soc(rx_soc), .rx_prty(rx_prty)
   );

   // behavioural reference model
   int          cnt [4];
   int          wcnt [4];
   bit          wacc [4];
   logic [15:0] st [4][$];
   logic [15:0] pend [4][$];
   bit          cand_v = 0, busy = 0;
   int          cand = 0, cur = 0, idx = 0;
   logic [15:0] e_data = '0;
   bit          e_soc = 0, e_prty = 1, e_clav = 0, e_oe = 0;

   initial begin
      for (int i = 0; i < 4; i++) begin cnt[i] = 0; wcnt[i] = 0; wacc[i] = 0; end
      cfg[0] = 5'h03; cfg[1] = 5'h11; cfg[2] = 5'h1E; cfg[3] = 5'h07;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         int pre [4];
         int m;
         int p;
         m = -1;
         for (int i = 3; i >= 0; i--) if (cfg[i] == rx_addr) m = i;
         for (int i = 0; i < 4; i++) pre[i] = cnt[i];
         e_oe   = (m >= 0);
         e_clav = (m >= 0) && (pre[m] > 0);
         e_soc  = 0;
         if (!rx_enb_n) begin
            if (!busy && cand_v && pre[cand] > 0) begin
               busy = 1; cur = cand; idx = 0; cand_v = 0;
            end
            if (busy) begin
               e_data = st[cur][idx];
               e_soc  = (idx == 0);
               e_prty = ~^e_data;
               idx++;
               if (idx == 27) begin
                  for (int k = 0; k < 27; k++) void'(st[cur].pop_front());
                  cnt[cur]--;
                  busy = 0;
               end
            end
         end else begin
            cand_v = (m >= 0);
            if (m >= 0) cand = m;
         end
         if (line_wr_en) begin
            p = int'(line_wr_port);
            if (wcnt[p] == 0) wacc[p] = (pre[p] < 2);
            if (wacc[p]) pend[p].push_back(line_wr_data);
            wcnt[p]++;
            if (wcnt[p] == 27) begin
               wcnt[p] = 0;
               if (wacc[p]) begin
                  foreach (pend[p][k]) st[p].push_back(pend[p][k]);
                  cnt[p]++;
               end
               pend[p].delete();
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      chk(rx_clav_oe == e_oe, "R1 clav_oe", 32'(rx_clav_oe), 32'(e_oe));
      chk(rx_clav == e_clav, "R2 clav", 32'(rx_clav), 32'(e_clav));
      chk(rx_soc == e_soc, "R6 soc", 32'(rx_soc), 32'(e_soc));
      chk(rx_data == e_data, "R8 data", 32'(rx_data), 32'(e_data));
      chk(rx_prty == e_prty, "R7 parity", 32'(rx_prty), 32'(e_prty));
   end

   task automatic write_cell(input logic [1:0] p, input logic [15:0] base);
      for (int k = 0; k < 27; k++) begin
         line_wr_en = 1'b1; line_wr_port = p; line_wr_data = base + 16'(k);
         @(negedge clk);
      end
      line_wr_en = 1'b0;
   endtask

   task automatic poll(input logic [4:0] a);
      rx_addr = a; rx_enb_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic read_cell(input logic [4:0] a, input logic [15:0] first);
      int loads = 0;
      int cyc = 0;
      bit seen = 0;
      rx_addr = a; rx_enb_n = 1'b1;
      @(negedge clk);
      while (loads < 27) begin
         if (cyc % 5 == 3) begin
            rx_enb_n = 1'b1; rx_addr = 5'h1F;
         end else begin
            rx_enb_n = 1'b0; rx_addr = 5'h07; loads++;
         end
         @(negedge clk);
         if (loads == 1 && !seen) begin
            seen = 1;
            chk(rx_soc == 1'b1, "R5 soc on first word", 32'(rx_soc), 32'd1);
            chk(rx_data == first, "R5 first word", 32'(rx_data), 32'(first));
         end
         cyc++;
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      chk(rx_clav_oe == 0 && rx_soc == 0 && rx_data == 0 && rx_prty == 1,
          "R12 reset state", {rx_data, 12'd0, rx_clav_oe, rx_soc, rx_prty, rx_clav}, 32'd2);
      rst_n = 1'b1;
      @(negedge clk);

      poll(5'h03);
      chk(rx_clav_oe == 1, "R1 matched poll", 32'(rx_clav_oe), 32'd1);
      chk(rx_clav == 0, "R2 empty port", 32'(rx_clav), 32'd0);
      poll(5'h15);
      chk(rx_clav_oe == 0 && rx_clav == 0, "R3 unmatched poll", {rx_clav_oe, rx_clav}, 32'd0);

      write_cell(2'd0, 16'h1000);
      poll(5'h03);
      chk(rx_clav == 1, "R2 full cell", 32'(rx_clav), 32'd1);
      read_cell(5'h03, 16'h1000);
      poll(5'h03);
      chk(rx_clav == 0, "R8 cell freed", 32'(rx_clav), 32'd0);

      // R9: selected port has nothing
      poll(5'h11);
      held = rx_data;
      rx_enb_n = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(rx_soc == 0 && rx_data == held, "R9 empty select", {rx_data, 15'd0, rx_soc}, {held, 16'd0});
      end
      poll(5'h1F);

      // R10: third cell dropped
      write_cell(2'd2, 16'h2000);
      write_cell(2'd2, 16'h2100);
      write_cell(2'd2, 16'h2200);
      read_cell(5'h1E, 16'h2000);
      read_cell(5'h1E, 16'h2100);
      poll(5'h1E);
      chk(rx_clav == 0, "R10 third cell dropped", 32'(rx_clav), 32'd0);

      // R11: no restart without fresh selection
      write_cell(2'd0, 16'h4000);
      write_cell(2'd0, 16'h4100);
      read_cell(5'h03, 16'h4000);
      rx_addr = 5'h03;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(rx_soc == 0, "R11 no reselection", 32'(rx_soc), 32'd0);
      end
      poll(5'h1F);

      // R10: write into a port while it streams
      fork
         write_cell(2'd0, 16'h3000);
         read_cell(5'h03, 16'h4100);
      join
      poll(5'h03);
      chk(rx_clav == 1, "R10 write during read", 32'(rx_clav), 32'd1);
      read_cell(5'h03, 16'h3000);
      poll(5'h1F);

      // R4: shared address, lower index wins
      write_cell(2'd3, 16'h5A5A);
      cfg[3] = 5'h11;
      poll(5'h11);
      chk(rx_clav == 0, "R4 lower index wins", 32'(rx_clav), 32'd0);
      cfg[3] = 5'h07;
      poll(5'h07);
      chk(rx_clav == 1, "R4 own address", 32'(rx_clav), 32'd1);
      read_cell(5'h07, 16'h5A5A);
      chk(^{rx_data, rx_prty} == 1'b1, "R7 odd total", 32'(^{rx_data, rx_prty}), 32'd1);
      poll(5'h1F);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule